// File: doc/BRIEF.md
# Late-Write Synchronous Burst SRAM

A synchronous static RAM that keeps its data bus busy on every cycle, with reads and writes in any order. Commands, addresses and byte strobes are taken on the rising clock edge. The write data for a command arrives some edges later: one enabled edge later in flow-through mode, two in pipelined mode. Because of this lag, a read can be issued right after a write with no idle cycle between them. Any write data that has been captured but is still pending is merged into reads that target the same word.

A read drives data out after the edge that takes the command in flow-through mode, or one edge later from an output register in pipelined mode. Each command either loads a new address or advances a 2-bit burst counter. The counter steps in linear or interleaved order. Three chip enables qualify loads. A clock enable freezes the whole block. The output enable and the sleep input remove the output drive at once, without waiting for a clock edge.

The data pins are split into an input bus, an output bus and an output-enable pin, which drive a pad-level tri-state buffer. The array holds `2**ADDR_W` words of `NBYTES` bytes, each byte `BYTE_W` bits wide.

Top module: `lw_burst_sram`

## Requirements
- R1: Flow-through mode (`pipeSel` = 0). After the enabled edge that takes a read, `dOutEn` is high and `dOut` holds the word until the next enabled edge.
- R2: Pipelined mode (`pipeSel` = 1). Read data and `dOutEn` appear one enabled edge later than in flow-through mode.
- R3: Write data is sampled from `dIn` on the first enabled edge after the write command in flow-through mode, and on the second in pipelined mode. `dIn` is ignored on every other edge.
- R4: `byteWrN[b]` is active low and selects bits `[b*BYTE_W +: BYTE_W]`. Bytes whose strobe is high keep their old contents.
- R5: A load (`advance` = 0) starts an access only when `sel1N` = 0, `sel2` = 1 and `sel3N` = 0. Any other load is a deselect: no access, and no output drive for it.
- R6: While `clkEnN` = 1, clock edges are ignored. All state and `dOut` hold.
- R7: `advance` = 1 continues the current burst and keeps its read or write type. The chip enables and `wrEnN` are ignored. An advance after a deselect stays deselected.
- R8: With `orderSel` = 0, beat n of a burst uses address low bits (start + n) mod 4. The upper bits stay fixed.
- R9: With `orderSel` = 1, beat n uses address low bits start XOR n.
- R10: A read returns the newest data for every byte written by an earlier command, even if that write's data is still pending. Reads and writes may alternate on every edge.
- R11: `outEnN` = 1 forces `dOutEn` low at once, with no clock edge.
- R12: `sleep` = 1 forces `dOutEn` low at once, and edges taken while it is high are ignored.
- R13: While `rstN` = 0, `dOutEn` is low and no access is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| clkEnN | input | 1 | Clock enable, active low |
| sleep | input | 1 | Sleep, active high, asynchronous output off |
| pipeSel | input | 1 | 1 = pipelined, 0 = flow-through (static) |
| orderSel | input | 1 | 0 = linear burst, 1 = interleaved (static) |
| adr | input | ADDR_W | Word address |
| advance | input | 1 | 1 = advance burst, 0 = load address |
| wrEnN | input | 1 | Write enable, active low |
| byteWrN | input | NBYTES | Byte write strobes, active low |
| sel1N | input | 1 | Chip enable, active low |
| sel2 | input | 1 | Chip enable, active high |
| sel3N | input | 1 | Chip enable, active low |
| outEnN | input | 1 | Output enable, active low, asynchronous |
| dIn | input | NBYTES*BYTE_W | Write data |
| dOut | output | NBYTES*BYTE_W | Read data |
| dOutEn | output | 1 | Drive enable for the data pad |

## Verification
If a command stage is misaligned, `dOutEn` goes high one edge early or late. This shows within one or two cycles of any read. A wrong pending-write buffer or a bad merge lane shows as a wrong byte on the next read of that word, often on the very next edge when reads and writes alternate. A wrong burst counter shows on the second beat of a burst, and a mis-sampled write lag shows on the next read of that address.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic step;     // enabled edge: state may move
    logic capture;  // write data is due on dIn at this edge
    logic show;     // a read result is presented this cycle
    logic pipe;     // pipelined output register in use
  } ctl_stb_t;

endpackage

// File: rtl/lw_sram_ctrl.sv
module lw_sram_ctrl
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NBYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  logic              sleep,
  input  logic              pipeSel,
  input  logic              orderSel,
  input  logic [ADDR_W-1:0] adr,
  input  logic              advance,
  input  logic              wrEnN,
  input  logic [NBYTES-1:0] byteWrN,
  input  logic              sel1N,
  input  logic              sel2,
  input  logic              sel3N,
  output ctl_stb_t          stb,
  output logic [ADDR_W-1:0] rdAdr,
  output logic [ADDR_W-1:0] capAdr,
  output logic [NBYTES-1:0] capMask
);

  // Burst state
  op_e               opQ;
  logic [ADDR_W-1:0] startQ;
  logic [1:0]        beatQ;

  // Command stages: s1 = taken at last enabled edge, s2 = one before
  op_e               s1Op, s2Op;
  logic [ADDR_W-1:0] s1Adr, s2Adr;
  logic [NBYTES-1:0] s1Mask, s2Mask;

  logic              step, chipOn;
  op_e               nOp;
  logic [ADDR_W-1:0] nStart, nAdr;
  logic [1:0]        nBeat, nLow;
  op_e               dOp;

  assign step   = !clkEnN && !sleep;
  assign chipOn = !sel1N && sel2 && !sel3N;

  always_comb begin
    nOp    = opQ;
    nStart = startQ;
    nBeat  = beatQ + 2'd1;
    if (!advance) begin
      nStart = adr;
      nBeat  = 2'd0;
      if (chipOn) nOp = wrEnN ? OP_READ : OP_WRITE;
      else        nOp = OP_IDLE;
    end
    nLow = orderSel ? (nStart[1:0] ^ nBeat) : (nStart[1:0] + nBeat);
    nAdr = {nStart[ADDR_W-1:2], nLow};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opQ    <= OP_IDLE;
      startQ <= '0;
      beatQ  <= '0;
      s1Op   <= OP_IDLE;
      s1Adr  <= '0;
      s1Mask <= '1;
      s2Op   <= OP_IDLE;
      s2Adr  <= '0;
      s2Mask <= '1;
    end else if (step) begin
      opQ    <= nOp;
      startQ <= nStart;
      beatQ  <= nBeat;
      s1Op   <= nOp;
      s1Adr  <= nAdr;
      s1Mask <= byteWrN;
      s2Op   <= s1Op;
      s2Adr  <= s1Adr;
      s2Mask <= s1Mask;
    end
  end

  // Stage whose write data is due on the coming edge
  assign dOp     = pipeSel ? s2Op : s1Op;
  assign capAdr  = pipeSel ? s2Adr : s1Adr;
  assign capMask = pipeSel ? s2Mask : s1Mask;
  assign rdAdr   = s1Adr;

  always_comb begin
    stb.step    = step;
    stb.capture = step && (dOp == OP_WRITE);
    stb.show    = pipeSel ? (s2Op == OP_READ) : (s1Op == OP_READ);
    stb.pipe    = pipeSel;
  end

endmodule

// File: rtl/lw_sram_dp.sv
module lw_sram_dp
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 9
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctl_stb_t                 stb,
  input  logic [ADDR_W-1:0]        rdAdr,
  input  logic [ADDR_W-1:0]        capAdr,
  input  logic [NBYTES-1:0]        capMask,
  input  logic [NBYTES*BYTE_W-1:0] dIn,
  output logic [NBYTES*BYTE_W-1:0] dOut
);

  localparam int DATA_W = NBYTES * BYTE_W;
  localparam int WORDS  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [WORDS];

  // One-entry late-write buffer, committed on the next enabled edge
  logic              bufValid;
  logic [ADDR_W-1:0] bufAdr;
  logic [NBYTES-1:0] bufMask;
  logic [DATA_W-1:0] bufData;

  logic [DATA_W-1:0] outReg;
  logic [DATA_W-1:0] arrWord, viewWord, loadWord;
  logic              bufHit, capHit;

  assign arrWord = mem[rdAdr];
  assign bufHit  = bufValid && (bufAdr == rdAdr);
  assign capHit  = stb.capture && (capAdr == rdAdr);

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    localparam int LO = b * BYTE_W;
    assign viewWord[LO +: BYTE_W] = (bufHit && !bufMask[b]) ?
                                    bufData[LO +: BYTE_W] : arrWord[LO +: BYTE_W];
    assign loadWord[LO +: BYTE_W] = (capHit && !capMask[b]) ?
                                    dIn[LO +: BYTE_W] : viewWord[LO +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (stb.step && bufValid) begin
      for (int b = 0; b < NBYTES; b++) begin
        if (!bufMask[b]) mem[bufAdr][b*BYTE_W +: BYTE_W] <= bufData[b*BYTE_W +: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufValid <= 1'b0;
      bufAdr   <= '0;
      bufMask  <= '1;
      bufData  <= '0;
    end else if (stb.step) begin
      bufValid <= stb.capture;
      if (stb.capture) begin
        bufAdr  <= capAdr;
        bufMask <= capMask;
        bufData <= dIn;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     outReg <= '0;
    else if (stb.step && stb.pipe) outReg <= loadWord;
  end

  assign dOut = stb.pipe ? outReg : viewWord;

endmodule

// File: rtl/lw_burst_sram.sv
module lw_burst_sram
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 9,
  localparam int DATA_W = NBYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  logic              sleep,
  input  logic              pipeSel,
  input  logic              orderSel,
  input  logic [ADDR_W-1:0] adr,
  input  logic              advance,
  input  logic              wrEnN,
  input  logic [NBYTES-1:0] byteWrN,
  input  logic              sel1N,
  input  logic              sel2,
  input  logic              sel3N,
  input  logic              outEnN,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dOut,
  output logic              dOutEn
);

  ctl_stb_t          stb;
  logic [ADDR_W-1:0] rdAdr, capAdr;
  logic [NBYTES-1:0] capMask;

  lw_sram_ctrl #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) uCtl (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .sleep(sleep),
    .pipeSel(pipeSel), .orderSel(orderSel), .adr(adr), .advance(advance),
    .wrEnN(wrEnN), .byteWrN(byteWrN), .sel1N(sel1N), .sel2(sel2), .sel3N(sel3N),
    .stb(stb), .rdAdr(rdAdr), .capAdr(capAdr), .capMask(capMask)
  );

  lw_sram_dp #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .rdAdr(rdAdr), .capAdr(capAdr),
    .capMask(capMask), .dIn(dIn), .dOut(dOut)
  );

  assign dOutEn = stb.show && !outEnN && !sleep;

endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rstN,
  input logic              clkEnN,
  input logic              sleep,
  input logic              pipeSel,
  input logic              advance,
  input logic              wrEnN,
  input logic              sel1N,
  input logic              sel2,
  input logic              sel3N,
  input logic              outEnN,
  input logic [DATA_W-1:0] dOut,
  input logic              dOutEn
);

  logic stepNow, chipNow, flowLoad;
  assign stepNow  = !clkEnN && !sleep;
  assign chipNow  = !sel1N && sel2 && !sel3N;
  assign flowLoad = stepNow && !pipeSel && !advance;

  AST_OE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> !dOutEn) else $error("output enable ignored"); // R11

  AST_SLEEP_OFF: assert property (@(posedge clk) disable iff (!rstN)
    sleep |-> !dOutEn) else $error("sleep ignored"); // R12

  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rstN)
    (clkEnN || sleep) |=> $stable(dOut)) else $error("output moved on ignored edge"); // R6

  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (flowLoad && !chipNow) |=> !dOutEn) else $error("deselect drove bus"); // R5

  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (flowLoad && chipNow && !wrEnN) |=> !dOutEn) else $error("write drove bus"); // R3

  AST_READ_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    (flowLoad && chipNow && wrEnN) |=> (dOutEn || outEnN || sleep)) else $error("read not driven"); // R1

endmodule

bind lw_burst_sram lw_sram_chk #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .sleep(sleep), .pipeSel(pipeSel),
  .advance(advance), .wrEnN(wrEnN), .sel1N(sel1N), .sel2(sel2), .sel3N(sel3N),
  .outEnN(outEnN), .dOut(dOut), .dOutEn(dOutEn)
);

// File: tb/sim_lw_burst_sram.sv
module sim_lw_burst_sram;
  localparam int AW = 8;
  localparam int NB = 4;
  localparam int BW = 9;
  localparam int DW = NB * BW;
  localparam int OP_I = 0;
  localparam int OP_R = 1;
  localparam int OP_W = 2;

  typedef struct {
    int          op;
    logic [AW-1:0] adr;
    logic [NB-1:0] mask;
    bit          fwd;
    bit          burst;
  } bcmd_t;

  logic clk = 0, rstN = 0, clkEnN = 0, sleep = 0, pipeSel = 0, orderSel = 0;
  logic [AW-1:0] adr = '0;
  logic advance = 0, wrEnN = 1;
  logic [NB-1:0] byteWrN = '1;
  logic sel1N = 1, sel2 = 0, sel3N = 1, outEnN = 0;
  logic [DW-1:0] dIn = '0;
  logic [DW-1:0] dOut;
  logic dOutEn;

  lw_burst_sram #(.ADDR_W(AW), .NBYTES(NB), .BYTE_W(BW)) u0 (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .sleep(sleep), .pipeSel(pipeSel),
    .orderSel(orderSel), .adr(adr), .advance(advance), .wrEnN(wrEnN),
    .byteWrN(byteWrN), .sel1N(sel1N), .sel2(sel2), .sel3N(sel3N),
    .outEnN(outEnN), .dIn(dIn), .dOut(dOut), .dOutEn(dOutEn)
  );

  always #5 clk = ~clk;

  // Reference state
  logic [DW-1:0] refMem [1 << AW];
  bcmd_t c0, c1;
  int bOp = OP_I, bStart = 0, bBeat = 0;
  bit expShow = 0, lastStall = 0;
  logic [DW-1:0] expData = '0;
  string srcTag = "R1";
  string forceTag = "";
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  function automatic bcmd_t idleCmd();
    bcmd_t c;
    c.op = OP_I; c.adr = '0; c.mask = '1; c.fwd = 0; c.burst = 0;
    return c;
  endfunction

  function automatic string pickTag();
    if (forceTag != "") return forceTag;
    if (sleep) return "R12";
    if (outEnN) return "R11";
    if (lastStall) return "R6";
    if (!expShow) return "R5";
    return srcTag;
  endfunction

  task automatic checkOut();
    logic expEn;
    string tag;
    expEn = expShow && !outEnN && !sleep;
    tag = pickTag();
    checks++;
    if (dOutEn !== expEn) begin
      fails++;
      $display("FAIL %s: dOutEn=%0b expected %0b", tag, dOutEn, expEn);
    end else if (expEn && dOut !== expData) begin
      fails++;
      $display("FAIL %s: dOut=%h expected %h", tag, dOut, expData);
    end
  endtask

  task automatic cycle(input logic ceN, input logic slp, input logic oeN, input logic adv,
                       input logic weN, input logic [NB-1:0] bw, input logic [AW-1:0] a,
                       input logic e1N, input logic e2, input logic e3N);
    bcmd_t dueCmd, nc, src;
    logic [DW-1:0] wd;
    int low, eff;
    clkEnN = ceN; sleep = slp; outEnN = oeN; advance = adv; wrEnN = weN;
    byteWrN = bw; adr = a; sel1N = e1N; sel2 = e2; sel3N = e3N;
    dueCmd = pipeSel ? c1 : c0;
    wd = {$urandom, $urandom};
    dIn = wd;
    #1;
    checkOut();
    @(posedge clk);
    if (!ceN && !slp) begin
      if (dueCmd.op == OP_W)
        for (int b = 0; b < NB; b++)
          if (!dueCmd.mask[b]) refMem[dueCmd.adr][b*BW +: BW] = wd[b*BW +: BW];
      if (!adv) begin
        bStart = int'(a); bBeat = 0;
        bOp = (!e1N && e2 && !e3N) ? (weN ? OP_R : OP_W) : OP_I;
      end else bBeat = (bBeat + 1) % 4;
      low = orderSel ? ((bStart % 4) ^ bBeat) : (((bStart % 4) + bBeat) % 4);
      eff = (bStart / 4) * 4 + low;
      nc.op = bOp; nc.adr = eff[AW-1:0]; nc.mask = bw; nc.burst = (bBeat != 0);
      nc.fwd = (bOp == OP_R) && ((c0.op == OP_W && c0.adr == nc.adr) ||
                                 (c1.op == OP_W && c1.adr == nc.adr));
      c1 = c0; c0 = nc;
      src = pipeSel ? c1 : c0;
      expShow = (src.op == OP_R);
      expData = refMem[src.adr];
      if (src.fwd) srcTag = "R10";
      else if (src.burst) srcTag = orderSel ? "R9" : "R8";
      else srcTag = pipeSel ? "R2" : "R1";
      lastStall = 0;
    end else lastStall = 1;
    @(negedge clk);
  endtask

  task automatic idle();
    cycle(0, 0, 0, 0, 1, '1, '0, 1, 1, 0);
  endtask
  task automatic ld(input logic weN, input logic [NB-1:0] bw, input logic [AW-1:0] a);
    cycle(0, 0, 0, 0, weN, bw, a, 0, 1, 0);
  endtask
  task automatic adv(input logic [NB-1:0] bw);
    cycle(0, 0, 0, 1, 1'($urandom), bw, AW'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
  endtask

  task automatic resetPhase(input logic pipe, input logic order);
    repeat (3) idle();
    rstN = 0; pipeSel = pipe; orderSel = order;
    c0 = idleCmd(); c1 = idleCmd(); bOp = OP_I; bBeat = 0; expShow = 0; lastStall = 0;
    @(negedge clk); @(negedge clk);
    checks++;
    if (dOutEn !== 1'b0) begin
      fails++;
      $display("FAIL R13: dOutEn=%0b expected 0 in reset", dOutEn);
    end
    rstN = 1;
    @(negedge clk);
  endtask

  task automatic directed();
    forceTag = "R4";
    ld(0, 4'b1010, 8'h10); idle(); idle(); ld(1, '1, 8'h10); idle(); idle();
    forceTag = "R3";
    ld(0, 4'h0, 8'h21); ld(1, '1, 8'h21); ld(0, 4'h0, 8'h22); ld(1, '1, 8'h22);
    idle(); idle(); ld(1, '1, 8'h21); idle(); idle();
    forceTag = "R5";
    cycle(0, 0, 0, 0, 1, '1, 8'h10, 0, 0, 0);
    cycle(0, 0, 0, 0, 1, '1, 8'h10, 1, 1, 0);
    cycle(0, 0, 0, 0, 1, '1, 8'h10, 0, 1, 1);
    idle(); idle();
    forceTag = "R7";
    idle(); adv('1); adv('1); ld(1, '1, 8'h30); adv(4'h0); adv(4'h0); idle(); idle();
    forceTag = "";
    ld(1, '1, 8'h46); repeat (5) adv('1); idle(); idle();
    ld(0, 4'h0, 8'h4d); repeat (3) adv(4'b0110); ld(1, '1, 8'h4c); repeat (3) adv('1); idle(); idle();
    ld(1, '1, 8'h50);
    cycle(1, 0, 0, 0, 0, 4'h0, 8'h51, 0, 1, 0);
    cycle(1, 0, 0, 0, 0, 4'h0, 8'h51, 0, 1, 0);
    adv('1); idle(); idle();
  endtask

  task automatic randomRun(input int n);
    for (int i = 0; i < n; i++) begin
      logic ceN, slp, oeN, av, weN, e1N, e2, e3N;
      int k;
      ceN = (($urandom % 8) == 0);
      slp = (($urandom % 20) == 0);
      oeN = (($urandom % 10) == 0);
      av  = 1'($urandom);
      weN = 1'($urandom);
      k = (($urandom % 6) == 0) ? int'($urandom % 3) : 3;
      e1N = (k == 0); e2 = (k != 1); e3N = (k == 2);
      cycle(ceN, slp, oeN, av, weN, NB'($urandom), AW'($urandom % 16), e1N, e2, e3N);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: cycles=%0d expected below 150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    c0 = idleCmd(); c1 = idleCmd();
    @(negedge clk); @(negedge clk);
    checks++;
    if (dOutEn !== 1'b0) begin
      fails++;
      $display("FAIL R13: dOutEn=%0b expected 0 at reset", dOutEn);
    end
    rstN = 1;
    @(negedge clk);
    for (int a = 0; a < (1 << AW); a += 4) begin
      ld(0, 4'h0, AW'(a)); adv(4'h0); adv(4'h0); adv(4'h0);
    end
    for (int ph = 0; ph < 4; ph++) begin
      resetPhase(ph[1], ph[0]);
      directed();
      randomRun(1500);
    end
    repeat (3) idle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule